// File: doc/BRIEF.md
# Statistics Counter Bank Controller

A bank of event counters, one per increment strobe, kept for frame statistics. Each cycle that a strobe is high, its counter advances by one. A control register sets how the whole bank behaves. A counter can wrap or stop at its maximum. A read of the counter can zero it. All counters can be held still. Software can clear every counter at once. For debug, software can also load every counter with a value just short of half scale or just short of full scale. That makes the half-scale and full-scale events quick to reach.

A status register marks each counter whose count has just reached half scale, or has just wrapped or saturated at full scale. The marks are ORed, through a per-counter mask, onto a single interrupt line. A simple word-addressed port gives access to everything. The port has byte-lane enables, and reads return data combinationally in the cycle of the request.

Top module: `stat_ctr_bank`

## Requirements
- R1: Word address 0 is the control register, with bit 0 clear-all, bit 1 stop-at-maximum, bit 2 clear-on-read, bit 3 freeze, bit 4 preset and bit 5 preset level. Control fields are written only when byte lane 0 is enabled. Bits 31:6 read as zero. Bits 0 and 4 read back as 0 once their one action cycle has passed. Address 1 is the read-only status register. Address 2 is the mask register. Address 4+i reads counter i.
- R2: Writing 1 to bit 0 clears every counter on the clock edge after the write, and then the bit reads 0.
- R3: Writing 1 to bit 4 loads every counter on the edge after the write. The value is 0x7FFF_FFF0 when bit 5 is written 0, and 0xFFFF_FFF0 when bit 5 is written 1.
- R4: While freeze is set, increment strobes do not change any counter.
- R5: An increment at 0xFFFF_FFFF leaves the counter at 0xFFFF_FFFF when stop-at-maximum is set. When stop-at-maximum is clear, the counter goes to 0.
- R6: With clear-on-read set, a counter read returns the current value and zeroes the counter at the following edge, but only when byte lane 0 is enabled. This also happens while freeze is set. With clear-on-read clear, a read leaves the counter as it was.
- R7: Status bit i goes to 1 when an increment takes counter i from 0x7FFF_FFFF to 0x8000_0000. It also goes to 1 when an increment arrives at 0xFFFF_FFFF, whether the counter wraps or saturates. Preset and clear never set it.
- R8: Any read of counter i clears status bit i. If a set event falls in the same cycle as that read, the status bit ends up 1.
- R9: irq_o is 1 exactly when some status bit is 1 and its mask bit is 0.
- R10: Within one cycle, the order of precedence is clear-all, then preset, then clear-on-read, then increment.
- R11: After reset, all counters, the status register, the mask register and the control register are zero, and each strobe cycle adds exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| be_i | input | 4 | Byte-lane enables |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| inc_i | input | NUM_CTR | One increment strobe per counter |
| irq_o | output | 1 | Masked OR of the status bits |

## Verification
The strobe patterns step two counters together and then one alone, which shows that the strobes stay separate. Preset-based patterns step a counter one short of the half-scale point and then onto it, which separates an early status flag from a missed one. Bursts run past full scale with stop-at-maximum off and then on, which separates wrapping from saturating. Reads use lane masks with and without lane 0, and some coincide with strobes or with freeze, which pins down the clear-on-read condition and the precedence order, including set-over-clear on a status bit.

// File: rtl/stat_ctr_pkg.sv
package stat_ctr_pkg;
  localparam int unsigned DW         = 32;
  localparam int unsigned ADDR_CTRL  = 0;
  localparam int unsigned ADDR_STAT  = 1;
  localparam int unsigned ADDR_MASK  = 2;
  localparam int unsigned ADDR_CTR0  = 4;

  // bit 5 down to bit 0 of the control word
  typedef struct packed {
    logic lvl_full;
    logic preset;
    logic freeze;
    logic clr_on_rd;
    logic sat;
    logic clr_all;
  } ctrl_t;
endpackage

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_all_i,
  input  logic          preset_i,
  input  logic          lvl_full_i,
  input  logic          clr_rd_i,
  input  logic          inc_i,
  input  logic          freeze_i,
  input  logic          sat_i,
  input  logic          stat_clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          stat_o
);
  localparam logic [CW-1:0] ONES    = '1;
  localparam logic [CW-1:0] HALF_M1 = ONES >> 1;
  localparam logic [CW-1:0] PV_HALF = HALF_M1 - CW'(15);
  localparam logic [CW-1:0] PV_FULL = ONES - CW'(15);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          stat_q, inc_en, stat_set;

  assign inc_en   = inc_i && !freeze_i && !clr_all_i && !preset_i && !clr_rd_i;
  assign stat_set = inc_en && (cnt_q == HALF_M1 || cnt_q == ONES);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_all_i)     cnt_d = '0;
    else if (preset_i) cnt_d = lvl_full_i ? PV_FULL : PV_HALF;
    else if (clr_rd_i) cnt_d = '0;
    else if (inc_en) begin
      if (cnt_q == ONES) cnt_d = sat_i ? ONES : '0;
      else               cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      stat_q <= stat_set || (stat_q && !stat_clr_i);
    end
  end

  assign cnt_o  = cnt_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/stat_ctr_regs.sv
module stat_ctr_regs
  import stat_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR = 4,
  parameter int unsigned CW      = 32,
  parameter int unsigned AW      = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [AW-1:0]              addr_i,
  input  logic [3:0]                 be_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              rdata_o,
  input  logic [NUM_CTR-1:0][CW-1:0] cnt_i,
  input  logic [NUM_CTR-1:0]         stat_i,
  output ctrl_t                      ctrl_o,
  output logic [NUM_CTR-1:0]         mask_o,
  output logic [NUM_CTR-1:0]         clr_rd_o,
  output logic [NUM_CTR-1:0]         stat_clr_o
);
  logic  rd, wr_ctrl, wr_mask;
  ctrl_t ctrl_q;
  logic [NUM_CTR-1:0] mask_q;

  assign rd      = req_i && !we_i;
  assign wr_ctrl = req_i && we_i && addr_i == AW'(ADDR_CTRL) && be_i[0];
  assign wr_mask = req_i && we_i && addr_i == AW'(ADDR_MASK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else begin
      // action bits live for exactly one cycle
      ctrl_q.clr_all <= 1'b0;
      ctrl_q.preset  <= 1'b0;
      if (wr_ctrl) ctrl_q <= ctrl_t'(wdata_i[5:0]);
      for (int i = 0; i < NUM_CTR; i++)
        if (wr_mask && be_i[i/8]) mask_q[i] <= wdata_i[i];
    end
  end

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_hit
    logic hit;
    assign hit           = rd && addr_i == AW'(ADDR_CTR0 + g);
    assign stat_clr_o[g] = hit;
    assign clr_rd_o[g]   = hit && be_i[0] && ctrl_q.clr_on_rd;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      if (addr_i == AW'(ADDR_CTRL)) rdata_o = DW'(ctrl_q);
      if (addr_i == AW'(ADDR_STAT)) rdata_o = DW'(stat_i);
      if (addr_i == AW'(ADDR_MASK)) rdata_o = DW'(mask_q);
      for (int i = 0; i < NUM_CTR; i++)
        if (addr_i == AW'(ADDR_CTR0 + i)) rdata_o = DW'(cnt_i[i]);
    end
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/stat_ctr_bank.sv
module stat_ctr_bank
  import stat_ctr_pkg::*;
#(
  parameter int unsigned NUM_CTR = 4,
  parameter int unsigned CW      = 32,
  parameter int unsigned AW      = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [3:0]         be_i,
  input  logic [31:0]        wdata_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_CTR-1:0] inc_i,
  output logic               irq_o
);
  ctrl_t                      ctrl;
  logic [NUM_CTR-1:0][CW-1:0] cnt;
  logic [NUM_CTR-1:0]         stat, mask, clr_rd, stat_clr;

  stat_ctr_regs #(.NUM_CTR(NUM_CTR), .CW(CW), .AW(AW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .stat_i(stat), .ctrl_o(ctrl), .mask_o(mask),
    .clr_rd_o(clr_rd), .stat_clr_o(stat_clr)
  );

  for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
    stat_ctr_cell #(.CW(CW)) u_cell (
      .clk_i, .rst_ni,
      .clr_all_i (ctrl.clr_all),
      .preset_i  (ctrl.preset),
      .lvl_full_i(ctrl.lvl_full),
      .clr_rd_i  (clr_rd[g]),
      .inc_i     (inc_i[g]),
      .freeze_i  (ctrl.freeze),
      .sat_i     (ctrl.sat),
      .stat_clr_i(stat_clr[g]),
      .cnt_o     (cnt[g]),
      .stat_o    (stat[g])
    );
  end

  assign irq_o = |(stat & ~mask);
endmodule

module stat_ctr_bank_chk #(
  parameter int unsigned NUM_CTR = 4,
  parameter int unsigned CW      = 32,
  parameter int unsigned AW      = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic [AW-1:0]              addr_i,
  input logic [31:0]                rdata_o,
  input logic                       irq_o,
  input logic [5:0]                 ctrl,
  input logic [NUM_CTR-1:0][CW-1:0] cnt,
  input logic [NUM_CTR-1:0]         stat,
  input logic [NUM_CTR-1:0]         mask
);
  // R1
  ctrl_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == '0) |-> rdata_o[31:6] == '0);
  // R2
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl[0] |=> (cnt == '0 && !ctrl[0]));
  // R4
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[3] && !ctrl[0] && !ctrl[4] && !(req_i && !we_i)) |=> $stable(cnt));
  // R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[1] && cnt[0] == '1 && !ctrl[0] && !ctrl[4] && !(req_i && !we_i))
      |=> cnt[0] == '1);
  // R9
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (stat & ~mask) != '0);
  // R9
  irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&mask) |-> !irq_o);
endmodule

bind stat_ctr_bank stat_ctr_bank_chk #(.NUM_CTR(NUM_CTR), .CW(CW), .AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .ctrl(ctrl), .cnt(cnt), .stat(stat), .mask(mask)
);

// File: tb/stat_ctr_bank_bench.sv
module stat_ctr_bank_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int AW = 4;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_i = 1'b0, we_i = 1'b0, irq_o;
  logic [AW-1:0] addr_i = '0;
  logic [3:0]    be_i = '0;
  logic [31:0]   wdata_i = '0, rdata_o;
  logic [N-1:0]  inc_i = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  stat_ctr_bank #(.NUM_CTR(N), .CW(32), .AW(AW)) u_stat_ctr_bank (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hf);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = AW'(a); wdata_i = d; be_i = be;
    @(negedge clk_i);
    req_i = 0; we_i = 0; be_i = 0;
    @(negedge clk_i); // let one-cycle actions land
  endtask

  task automatic rd_inc(input int a, input logic [3:0] be, input logic [N-1:0] inc,
                        output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = AW'(a); be_i = be; inc_i = inc;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 0; be_i = 0; inc_i = 0;
  endtask

  task automatic rd(input int a, input logic [3:0] be, output logic [31:0] d);
    rd_inc(a, be, '0, d);
  endtask

  task automatic pulse(input logic [N-1:0] m, input int n);
    @(negedge clk_i);
    inc_i = m;
    repeat (n) @(negedge clk_i);
    inc_i = '0;
  endtask

  task automatic rchk(input string tag, input int a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, 4'b1110, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    rchk("R11 ctrl", 0, 0);
    rchk("R11 stat", 1, 0);
    rchk("R11 mask", 2, 0);
    for (int i = 0; i < N; i++) rchk("R11 cnt", 4 + i, 0);
    check("R11 irq", {31'b0, irq_o}, 0);
  endtask

  task automatic t_count;
    pulse(4'b0011, 5);
    pulse(4'b0010, 2);
    rchk("R11 cnt0", 4, 5);
    rchk("R11 cnt1", 5, 7);
    rchk("R11 cnt2", 6, 0);
    rchk("R6 no-ror read keeps", 5, 7);
  endtask

  task automatic t_clr_all;
    wr(0, 32'h1);
    rchk("R1 clr bit self-clears", 0, 0);
    rchk("R2 cnt0", 4, 0);
    rchk("R2 cnt1", 5, 0);
  endtask

  task automatic t_half;
    logic [31:0] d;
    wr(0, 32'h10);
    rchk("R1 preset bit self-clears", 0, 0);
    for (int i = 0; i < N; i++) rchk("R3 half", 4 + i, 32'h7fff_fff0);
    pulse(4'b0100, 15);
    rchk("R7 no flag below half", 1, 0);
    pulse(4'b0100, 1);
    rchk("R7 cnt2 half", 6 + 0, 32'h8000_0000);
    // the read above cleared status; rebuild it
    wr(0, 32'h10);
    pulse(4'b0100, 16);
    rchk("R7 flag at half", 1, 32'h4);
    check("R9 irq unmasked", {31'b0, irq_o}, 1);
    wr(2, 32'h4, 4'b0001);
    check("R9 irq masked", {31'b0, irq_o}, 0);
    wr(2, 32'h0, 4'b0001);
    check("R9 irq unmasked again", {31'b0, irq_o}, 1);
    rd(6, 4'b0001, d);
    rchk("R8 read clears flag", 1, 0);
    check("R9 irq gone", {31'b0, irq_o}, 0);
    // set and read-clear in the same cycle: set wins
    wr(0, 32'h10);
    pulse(4'b0100, 15);
    rd_inc(6, 4'b0001, 4'b0100, d);
    check("R8 read value", d, 32'h7fff_ffff);
    rchk("R8 set wins", 1, 32'h4);
    rd(6, 4'b0001, d);
  endtask

  task automatic t_wrap_sat;
    logic [31:0] d;
    wr(0, 32'h30);
    rchk("R1 level kept", 0, 32'h20);
    rchk("R3 full", 4, 32'hffff_fff0);
    pulse(4'b0001, 16);
    rchk("R5 wrap", 4 + 0, 32'h0);
    wr(0, 32'h30);
    pulse(4'b0001, 16);
    rchk("R7 flag on wrap", 1, 32'h1);
    rd(4, 4'b0001, d);
    wr(0, 32'h32);
    pulse(4'b0001, 20);
    rchk("R7 flag on saturate", 1, 32'h1);
    rchk("R5 saturate", 4, 32'hffff_ffff);
    rchk("R1 ctrl readback", 0, 32'h22);
  endtask

  task automatic t_ror;
    logic [31:0] d;
    wr(0, 32'h5);
    pulse(4'b1000, 9);
    rd(7, 4'b1110, d); check("R6 no lane0 value", d, 9);
    rd(7, 4'b1110, d); check("R6 no lane0 kept", d, 9);
    rd(7, 4'b0001, d); check("R6 lane0 value", d, 9);
    rd(7, 4'b0001, d); check("R6 lane0 cleared", d, 0);
  endtask

  task automatic t_freeze;
    logic [31:0] d;
    wr(0, 32'h1);
    pulse(4'b0010, 3);
    wr(0, 32'h8);
    pulse(4'b0010, 5);
    rchk("R4 frozen", 5, 3);
    wr(0, 32'hc);
    rd(5, 4'b0001, d); check("R6 freeze read", d, 3);
    rd(5, 4'b0001, d); check("R6 freeze cleared", d, 0);
  endtask

  task automatic t_prio;
    logic [31:0] d;
    wr(0, 32'h5);
    pulse(4'b1000, 4);
    rd_inc(7, 4'b0001, 4'b1000, d);
    check("R10 read value", d, 4);
    rchk("R10 clear beats inc", 7, 0);
    wr(0, 32'h10);
    wr(0, 32'h11);
    rchk("R10 clear-all beats preset", 4, 0);
    rchk("R10 clear-all beats preset c3", 7, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_count();
    t_clr_all();
    t_half();
    t_wrap_sat();
    t_ror();
    t_freeze();
    t_prio();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule